// File: doc/BRIEF.md
# Operand Fetch Addressing-Mode Sequencer

This block is the operand-gathering stage of a compact 8-bit processor whose general registers can also be used as 16-bit pairs. Decode hands it an addressing-mode code and two register selectors (a source and a destination) with a one-cycle `start` pulse. The block then walks through the byte reads that the mode needs on a single read port. The port has combinational return: `mem_rdata` belongs to `mem_addr` in the same cycle that `mem_rd` is high. When the last step is complete, the block presents the operand on `fetched`. It also presents a memory-destination flag with its address and the number of memory reads spent, and it pulses `done` for one cycle.

The register file sits inside the block. The sequencer advances the program counter past immediate bytes. It applies HL post-increment or post-decrement, and it writes the flag register for the stack-relative mode. Software-visible register contents are reached through a small port with a combinational read and a write that lands on the next clock edge. The execute stage, including the ALU and the memory stores, lies outside this block.

Top module: `opfetch_seq`

## Requirements
- R1: After reset, PC reads 0x0100, every other register (including SP and the flags) reads 0, and `busy`, `done` and `err` are low.
- R2: Register port selectors are: A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7, AF=8, BC=9, DE=10, HL=11, SP=12, PC=13. A pair reads as {first register, second register}, so the first register is the high byte. Writing an 8-bit register stores only bits 7:0 of `rf_wdata`. A port write made while `busy` is high is ignored.
- R3: Mode 2 (8-bit immediate) performs one read at PC. It returns that byte zero-extended, adds 1 to PC and reports 1 cycle.
- R4: Mode 3 (16-bit immediate) reads PC then PC+1. It returns {second byte, first byte}, adds 2 to PC and reports 2 cycles.
- R5: Mode 4 (indirect load) reads at the source register's value and reports 1 cycle. Mode 5 (indirect store) performs no read: it returns the source value and raises `dst_mem` with the destination register's value as `dst_addr`. In both modes, an address register of C gives the address 0xFF00 | C.
- R6: Mode 11 (high-page store) reads an offset byte at PC. It sets `dst_addr` to 0xFF00 | offset, raises `dst_mem`, returns the source value, adds 1 to PC and reports 1 cycle. Mode 10 (high-page load) reads the offset, then reads at 0xFF00 | offset, adds 1 to PC and reports 2 cycles.
- R7: Modes 6 and 7 (HL loads) read at HL and return the byte. Mode 6 then writes HL+1 and mode 7 writes HL−1, both modulo 2^16.
- R8: Modes 8 and 9 (HL stores) perform no read. They return the source value, raise `dst_mem` with `dst_addr` equal to HL, and then write HL+1 (mode 8) or HL−1 (mode 9).
- R9: Mode 12 (absolute load) reads a little-endian address at PC and PC+1, then reads data from that address. It adds 2 to PC and reports 3 cycles. Mode 13 (absolute store) reads the address into `dst_addr`, raises `dst_mem`, returns the source value, adds 2 to PC and reports 2 cycles.
- R10: Mode 14 (stack-relative) reads an offset byte at PC, adds 1 to PC and returns SP plus the sign-extended offset. In the flags register (Z bit 7, N bit 6, H bit 5, C bit 4), Z and N are cleared. H is set if the low-nibble sum of SP and offset reaches 0x10, and C is set if the low-byte sum reaches 0x100. Bits 3:0 are unchanged.
- R11: Mode 0 (none) returns 0 and mode 1 (register) returns the source value, both with no reads. For every mode, `done` is high for exactly one cycle, `reads+1` cycles after the `start` edge, and `cycles` equals the number of cycles in which `mem_rd` was high.
- R12: Mode code 15 is unrecognised. It sets `err`, which stays high until reset. It performs no read, does not raise `done`, and leaves the block idle and able to accept a new start.
- R13: A `start` pulse while `busy` is high is ignored and does not disturb the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fetch when idle |
| mode | input | 4 | Addressing-mode code |
| dst_sel | input | 4 | Destination register selector |
| src_sel | input | 4 | Source register selector |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid in the strobe cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky unrecognised-mode flag |
| fetched | output | 16 | Operand value |
| dst_mem | output | 1 | Destination is memory |
| dst_addr | output | 16 | Destination memory address |
| cycles | output | 3 | Memory reads spent by the last fetch |
| rf_we | input | 1 | Register port write enable |
| rf_sel | input | 4 | Register port selector |
| rf_wdata | input | 16 | Register port write data |
| rf_rdata | output | 16 | Register port read data |

## Verification
The assertions check the following on every cycle:
- `done` lasts a single cycle.
- Reads occur only while busy.
- The reported cycle count equals the reads actually strobed.
- PC moves by exactly one on each immediate-byte read and holds otherwise.
- HL steps by exactly one on each post-adjust event.
- `err` never falls.
- A high-page store always targets page 0xFF.

Other behaviour can only be shown by the bench's scenarios, because it depends on values chosen in the test:
- the little-endian byte order;
- the substitution of 0xFF00 | C;
- the 16-bit wrap of HL;
- sign extension and the H/C flag values of the stack-relative mode;
- a port write or a second start being ignored while busy.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int MODE_W = 4;
  localparam int SEL_W  = 4;
  localparam logic [AW-1:0] HIGH_PAGE = 16'hFF00;

  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  typedef enum logic [MODE_W-1:0] {
    M_NONE     = 4'd0,
    M_REG      = 4'd1,
    M_IMM8     = 4'd2,
    M_IMM16    = 4'd3,
    M_LD_IND   = 4'd4,
    M_ST_IND   = 4'd5,
    M_LD_HLINC = 4'd6,
    M_LD_HLDEC = 4'd7,
    M_ST_HLINC = 4'd8,
    M_ST_HLDEC = 4'd9,
    M_LD_HIGH  = 4'd10,
    M_ST_HIGH  = 4'd11,
    M_LD_ABS   = 4'd12,
    M_ST_ABS   = 4'd13,
    M_SP_REL   = 4'd14,
    M_BAD      = 4'd15
  } opmode_e;

  typedef enum logic [SEL_W-1:0] {
    R_A = 4'd0, R_F = 4'd1, R_B = 4'd2, R_C = 4'd3,
    R_D = 4'd4, R_E = 4'd5, R_H = 4'd6, R_L = 4'd7,
    R_AF = 4'd8, R_BC = 4'd9, R_DE = 4'd10, R_HL = 4'd11,
    R_SP = 4'd12, R_PC = 4'd13, R_X0 = 4'd14, R_X1 = 4'd15
  } rsel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LO, S_HI, S_IND, S_FIN
  } seq_st_e;

  typedef struct packed {
    logic [AW-1:0] sum;
    logic          h;
    logic          c;
  } sprel_t;

  function automatic logic [AW-1:0] high_addr(input logic [DW-1:0] ofs);
    return HIGH_PAGE | {{(AW-DW){1'b0}}, ofs};
  endfunction

  function automatic logic [AW-1:0] join_le(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic sprel_t sp_rel(input logic [AW-1:0] sp, input logic [DW-1:0] ofs);
    sprel_t     r;
    logic [4:0] nib;
    logic [DW:0] byt;
    nib   = {1'b0, sp[3:0]} + {1'b0, ofs[3:0]};
    byt   = {1'b0, sp[DW-1:0]} + {1'b0, ofs};
    r.sum = sp + {{(AW-DW){ofs[DW-1]}}, ofs};
    r.h   = nib[4];
    r.c   = byt[DW];
    return r;
  endfunction

  function automatic logic [DW-1:0] sprel_flags(input logic [DW-1:0] f, input logic h, input logic c);
    logic [DW-1:0] n;
    n         = f;
    n[FLAG_Z] = 1'b0;
    n[FLAG_N] = 1'b0;
    n[FLAG_H] = h;
    n[FLAG_C] = c;
    return n;
  endfunction
endpackage

// File: rtl/opf_regfile.sv
module opf_regfile
  import opf_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = 16'h0100,
  parameter int            N_RD     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     rd_sel [N_RD],
  output logic [AW-1:0]        rd_val [N_RD],
  output logic [AW-1:0]        pc,
  output logic [AW-1:0]        sp,
  output logic [AW-1:0]        hl,
  output logic [DW-1:0]        f_val,
  input  logic                 ext_we,
  input  logic [SEL_W-1:0]     ext_sel,
  input  logic [AW-1:0]        ext_wd,
  input  logic                 pc_we,
  input  logic [AW-1:0]        pc_wd,
  input  logic                 hl_we,
  input  logic [AW-1:0]        hl_wd,
  input  logic                 f_we,
  input  logic [DW-1:0]        f_wd
);
  localparam int N_R8  = 8;
  localparam int IDX_W = $clog2(N_R8);
  localparam logic [IDX_W-1:0] IDX_F = 3'd1;
  localparam logic [IDX_W-1:0] IDX_H = 3'd6;
  localparam logic [IDX_W-1:0] IDX_L = 3'd7;

  logic [DW-1:0] r8 [N_R8];
  logic [AW-1:0] sp_q, pc_q;

  assign pc    = pc_q;
  assign sp    = sp_q;
  assign hl    = {r8[IDX_H], r8[IDX_L]};
  assign f_val = r8[IDX_F];

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    always_comb begin
      unique case (rd_sel[g][3:2])
        2'b00, 2'b01: rd_val[g] = {{(AW-DW){1'b0}}, r8[rd_sel[g][2:0]]};
        2'b10:        rd_val[g] = {r8[{rd_sel[g][1:0], 1'b0}], r8[{rd_sel[g][1:0], 1'b1}]};
        default: begin
          if (rd_sel[g][1:0] == 2'b00)      rd_val[g] = sp_q;
          else if (rd_sel[g][1:0] == 2'b01) rd_val[g] = pc_q;
          else                              rd_val[g] = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_R8; i++) r8[i] <= '0;
      sp_q <= '0;
      pc_q <= RESET_PC;
    end else begin
      if (ext_we) begin
        unique case (ext_sel[3:2])
          2'b00, 2'b01: r8[ext_sel[2:0]] <= ext_wd[DW-1:0];
          2'b10: begin
            r8[{ext_sel[1:0], 1'b0}] <= ext_wd[AW-1:DW];
            r8[{ext_sel[1:0], 1'b1}] <= ext_wd[DW-1:0];
          end
          default: begin
            if (ext_sel[1:0] == 2'b00)      sp_q <= ext_wd;
            else if (ext_sel[1:0] == 2'b01) pc_q <= ext_wd;
          end
        endcase
      end
      if (pc_we) pc_q <= pc_wd;
      if (hl_we) begin
        r8[IDX_H] <= hl_wd[AW-1:DW];
        r8[IDX_L] <= hl_wd[DW-1:0];
      end
      if (f_we) r8[IDX_F] <= f_wd;
    end
  end
endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              src_is_c,
  input  logic              dst_is_c,
  input  logic [AW-1:0]     src_val,
  input  logic [AW-1:0]     dst_val,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     sp,
  input  logic [AW-1:0]     hl,
  input  logic [DW-1:0]     f_val,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic              pc_we,
  output logic [AW-1:0]     pc_wd,
  output logic              hl_we,
  output logic [AW-1:0]     hl_wd,
  output logic              f_we,
  output logic [DW-1:0]     f_wd,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [AW-1:0]     fetched,
  output logic              dst_mem,
  output logic [AW-1:0]     dst_addr,
  output logic [CYC_W-1:0]  cycles,
  output logic              ev_byte,
  output logic              ev_hl_inc,
  output logic              ev_hl_dec
);
  seq_st_e          st;
  opmode_e          md;
  opmode_e          req_md;
  logic [DW-1:0]    lo_q;
  logic [AW-1:0]    ind_q;
  logic [AW-1:0]    fetched_q, dst_addr_q;
  logic             dst_mem_q, err_q;
  logic [CYC_W-1:0] cyc_q;
  logic             accept;
  logic             hl_up;
  sprel_t           spr;

  assign req_md  = opmode_e'(mode_in);
  assign accept  = (st == S_IDLE) && start;
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign err     = err_q;
  assign fetched = fetched_q;
  assign dst_mem = dst_mem_q;
  assign dst_addr = dst_addr_q;
  assign cycles  = cyc_q;

  assign ev_byte = (st == S_LO) || (st == S_HI);
  assign mem_rd  = ev_byte || (st == S_IND);
  assign mem_addr = (st == S_IND) ? ind_q : pc;
  assign pc_we   = ev_byte;
  assign pc_wd   = pc + 16'd1;

  always_comb begin
    hl_we = 1'b0;
    hl_up = 1'b0;
    if (accept && (req_md == M_ST_HLINC || req_md == M_ST_HLDEC)) begin
      hl_we = 1'b1;
      hl_up = (req_md == M_ST_HLINC);
    end else if (st == S_IND && (md == M_LD_HLINC || md == M_LD_HLDEC)) begin
      hl_we = 1'b1;
      hl_up = (md == M_LD_HLINC);
    end
  end
  assign hl_wd     = hl_up ? hl + 16'd1 : hl - 16'd1;
  assign ev_hl_inc = hl_we && hl_up;
  assign ev_hl_dec = hl_we && !hl_up;

  assign spr  = sp_rel(sp, mem_rdata);
  assign f_we = (st == S_LO) && (md == M_SP_REL);
  assign f_wd = sprel_flags(f_val, spr.h, spr.c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      md         <= M_NONE;
      lo_q       <= '0;
      ind_q      <= '0;
      fetched_q  <= '0;
      dst_addr_q <= '0;
      dst_mem_q  <= 1'b0;
      cyc_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          md         <= req_md;
          cyc_q      <= '0;
          dst_mem_q  <= 1'b0;
          dst_addr_q <= '0;
          fetched_q  <= '0;
          unique case (req_md)
            M_NONE: st <= S_FIN;
            M_REG: begin
              fetched_q <= src_val;
              st        <= S_FIN;
            end
            M_IMM8, M_IMM16, M_LD_HIGH, M_LD_ABS, M_SP_REL: st <= S_LO;
            M_ST_HIGH, M_ST_ABS: begin
              fetched_q <= src_val;
              st        <= S_LO;
            end
            M_LD_IND: begin
              ind_q <= src_is_c ? high_addr(src_val[DW-1:0]) : src_val;
              st    <= S_IND;
            end
            M_ST_IND: begin
              fetched_q  <= src_val;
              dst_addr_q <= dst_is_c ? high_addr(dst_val[DW-1:0]) : dst_val;
              dst_mem_q  <= 1'b1;
              st         <= S_FIN;
            end
            M_LD_HLINC, M_LD_HLDEC: begin
              ind_q <= hl;
              st    <= S_IND;
            end
            M_ST_HLINC, M_ST_HLDEC: begin
              fetched_q  <= src_val;
              dst_addr_q <= hl;
              dst_mem_q  <= 1'b1;
              st         <= S_FIN;
            end
            default: begin
              err_q <= 1'b1;
              st    <= S_IDLE;
            end
          endcase
        end
        S_LO: begin
          lo_q  <= mem_rdata;
          cyc_q <= cyc_q + 1'b1;
          unique case (md)
            M_IMM8: begin
              fetched_q <= {{(AW-DW){1'b0}}, mem_rdata};
              st        <= S_FIN;
            end
            M_SP_REL: begin
              fetched_q <= spr.sum;
              st        <= S_FIN;
            end
            M_ST_HIGH: begin
              dst_addr_q <= high_addr(mem_rdata);
              dst_mem_q  <= 1'b1;
              st         <= S_FIN;
            end
            M_LD_HIGH: begin
              ind_q <= high_addr(mem_rdata);
              st    <= S_IND;
            end
            default: st <= S_HI;
          endcase
        end
        S_HI: begin
          cyc_q <= cyc_q + 1'b1;
          unique case (md)
            M_IMM16: begin
              fetched_q <= join_le(lo_q, mem_rdata);
              st        <= S_FIN;
            end
            M_LD_ABS: begin
              ind_q <= join_le(lo_q, mem_rdata);
              st    <= S_IND;
            end
            default: begin
              dst_addr_q <= join_le(lo_q, mem_rdata);
              dst_mem_q  <= 1'b1;
              st         <= S_FIN;
            end
          endcase
        end
        S_IND: begin
          cyc_q     <= cyc_q + 1'b1;
          fetched_q <= {{(AW-DW){1'b0}}, mem_rdata};
          st        <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Checks on the sequencer's own outputs
  logic [CYC_W-1:0] rd_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_seen <= '0;
    else if (accept) rd_seen <= '0;
    else if (mem_rd) rd_seen <= rd_seen + 1'b1;
  end

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_read_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
  p_cycles_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles == rd_seen));
  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_bad_stays_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_in == M_BAD) |=> (!busy && err));
  p_high_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && md == M_ST_HIGH) |-> (dst_mem && dst_addr[AW-1:DW] == HIGH_PAGE[AW-1:DW]));
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import opf_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0100,
  parameter int          CYC_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [3:0]        dst_sel,
  input  logic [3:0]        src_sel,
  output logic              mem_rd,
  output logic [15:0]       mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [15:0]       fetched,
  output logic              dst_mem,
  output logic [15:0]       dst_addr,
  output logic [CYC_W-1:0]  cycles,
  input  logic              rf_we,
  input  logic [3:0]        rf_sel,
  input  logic [15:0]       rf_wdata,
  output logic [15:0]       rf_rdata
);
  localparam int N_RD   = 3;
  localparam int RD_SRC = 0;
  localparam int RD_DST = 1;
  localparam int RD_EXT = 2;

  logic [SEL_W-1:0] rd_sel [N_RD];
  logic [AW-1:0]    rd_val [N_RD];
  logic [AW-1:0]    pc, sp, hl;
  logic [DW-1:0]    f_val;
  logic             pc_we, hl_we, f_we;
  logic [AW-1:0]    pc_wd, hl_wd;
  logic [DW-1:0]    f_wd;
  logic             ext_we_g;
  logic             ev_byte, ev_hl_inc, ev_hl_dec;

  assign rd_sel[RD_SRC] = src_sel;
  assign rd_sel[RD_DST] = dst_sel;
  assign rd_sel[RD_EXT] = rf_sel;
  assign rf_rdata       = rd_val[RD_EXT];
  assign ext_we_g       = rf_we && !busy;

  opf_regfile #(.RESET_PC(RESET_PC), .N_RD(N_RD)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_sel(rd_sel), .rd_val(rd_val),
    .pc(pc), .sp(sp), .hl(hl), .f_val(f_val),
    .ext_we(ext_we_g), .ext_sel(rf_sel), .ext_wd(rf_wdata),
    .pc_we(pc_we), .pc_wd(pc_wd),
    .hl_we(hl_we), .hl_wd(hl_wd),
    .f_we(f_we), .f_wd(f_wd)
  );

  opf_seq #(.CYC_W(CYC_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .mode_in(mode),
    .src_is_c(src_sel == R_C), .dst_is_c(dst_sel == R_C),
    .src_val(rd_val[RD_SRC]), .dst_val(rd_val[RD_DST]),
    .pc(pc), .sp(sp), .hl(hl), .f_val(f_val),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .pc_we(pc_we), .pc_wd(pc_wd),
    .hl_we(hl_we), .hl_wd(hl_wd),
    .f_we(f_we), .f_wd(f_wd),
    .busy(busy), .done(done), .err(err),
    .fetched(fetched), .dst_mem(dst_mem), .dst_addr(dst_addr),
    .cycles(cycles),
    .ev_byte(ev_byte), .ev_hl_inc(ev_hl_inc), .ev_hl_dec(ev_hl_dec)
  );

  // PC and HL movement seen at the register file outputs
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> (pc == $past(pc) + 16'd1));
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_byte && !(ext_we_g && rf_sel == R_PC)) |=> $stable(pc));
  p_hl_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hl_inc |=> (hl == $past(hl) + 16'd1));
  p_hl_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hl_dec |=> (hl == $past(hl) - 16'd1));
endmodule

// File: tb/test_opfetch_seq.sv
module test_opfetch_seq;
  import opf_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_WAIT   = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0, dst_sel = '0, src_sel = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        busy, done, err, dst_mem;
  logic [15:0] fetched, dst_addr;
  logic [2:0]  cycles;
  logic        rf_we = 1'b0;
  logic [3:0]  rf_sel = '0;
  logic [15:0] rf_wdata = '0;
  logic [15:0] rf_rdata;

  int n_chk = 0;
  int n_err = 0;
  int lat, nrd;
  logic [15:0] rd_log [4];

  logic        ov_en   [4];
  logic [15:0] ov_addr [4];
  logic [7:0]  ov_data [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  opfetch_seq i_opfetch_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .dst_sel(dst_sel), .src_sel(src_sel),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .err(err), .fetched(fetched),
    .dst_mem(dst_mem), .dst_addr(dst_addr), .cycles(cycles),
    .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] bg(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always_comb begin
    mem_rdata = bg(mem_addr);
    for (int k = 0; k < 4; k++)
      if (ov_en[k] && ov_addr[k] == mem_addr) mem_rdata = ov_data[k];
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr_mem();
    for (int k = 0; k < 4; k++) ov_en[k] = 1'b0;
  endtask

  task automatic set_mem(input int k, input logic [15:0] a, input logic [7:0] d);
    ov_addr[k] = a; ov_data[k] = d; ov_en[k] = 1'b1;
  endtask

  task automatic wr_reg(input logic [3:0] sel, input logic [15:0] v);
    @(negedge clk); rf_we = 1'b1; rf_sel = sel; rf_wdata = v;
    @(negedge clk); rf_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] sel, output logic [15:0] v);
    rf_sel = sel; #1; v = rf_rdata;
  endtask

  task automatic wait_done();
    lat = 1; nrd = 0;
    while (!done && lat < MAX_WAIT) begin
      if (mem_rd) begin
        if (nrd < 4) rd_log[nrd] = mem_addr;
        nrd++;
      end
      @(negedge clk); lat++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R11 done never seen: actual 0 expected 1");
    end
  endtask

  task automatic op(input string req, input opmode_e m, input logic [3:0] d, input logic [3:0] s, input int exp_rd);
    @(negedge clk); start = 1'b1; mode = m; dst_sel = d; src_sel = s;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(req, "read count", nrd, exp_rd);
    chk("R11", "latency", lat, exp_rd + 1);
    chk("R11", "cycles output", cycles, exp_rd);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_reg(R_PC, v); chk("R1", "pc", v, 16'h0100);
    rd_reg(R_AF, v); chk("R1", "af", v, 0);
    rd_reg(R_HL, v); chk("R1", "hl", v, 0);
    rd_reg(R_SP, v); chk("R1", "sp", v, 0);
    chk("R1", "busy/done/err", {busy, done, err}, 0);
  endtask

  task automatic t_regport();
    logic [15:0] v;
    wr_reg(R_HL, 16'h1234);
    rd_reg(R_H, v); chk("R2", "high byte of pair", v, 16'h0012);
    rd_reg(R_L, v); chk("R2", "low byte of pair", v, 16'h0034);
    wr_reg(R_B, 16'hABCD);
    rd_reg(R_B, v); chk("R2", "8-bit write truncation", v, 16'h00CD);
    wr_reg(R_C, 16'h0077);
    rd_reg(R_BC, v); chk("R2", "pair read order", v, 16'hCD77);
  endtask

  task automatic t_imm8();
    logic [15:0] v;
    clr_mem(); wr_reg(R_PC, 16'h0200); set_mem(0, 16'h0200, 8'h7E);
    op("R3", M_IMM8, R_A, R_A, 1);
    chk("R3", "read address", rd_log[0], 16'h0200);
    chk("R3", "fetched", fetched, 16'h007E);
    chk("R3", "dst_mem", dst_mem, 0);
    rd_reg(R_PC, v); chk("R3", "pc", v, 16'h0201);
  endtask

  task automatic t_imm16();
    logic [15:0] v;
    clr_mem(); wr_reg(R_PC, 16'h0300);
    set_mem(0, 16'h0300, 8'h34); set_mem(1, 16'h0301, 8'h12);
    op("R4", M_IMM16, R_BC, R_A, 2);
    chk("R4", "second read address", rd_log[1], 16'h0301);
    chk("R4", "little-endian value", fetched, 16'h1234);
    rd_reg(R_PC, v); chk("R4", "pc", v, 16'h0302);
  endtask

  task automatic t_indirect();
    clr_mem();
    wr_reg(R_C, 16'h0042); wr_reg(R_DE, 16'hC123); wr_reg(R_A, 16'h0099);
    op("R5", M_LD_IND, R_A, R_C, 1);
    chk("R5", "C address on load", rd_log[0], 16'hFF42);
    chk("R5", "load data", fetched, {8'h00, bg(16'hFF42)});
    op("R5", M_LD_IND, R_A, R_DE, 1);
    chk("R5", "DE address on load", rd_log[0], 16'hC123);
    op("R5", M_ST_IND, R_C, R_A, 0);
    chk("R5", "C address on store", dst_addr, 16'hFF42);
    chk("R5", "store flag and data", {dst_mem, fetched}, {1'b1, 16'h0099});
    op("R5", M_ST_IND, R_DE, R_A, 0);
    chk("R5", "DE address on store", dst_addr, 16'hC123);
  endtask

  task automatic t_high();
    logic [15:0] v;
    clr_mem(); wr_reg(R_A, 16'h005A); wr_reg(R_PC, 16'h0400);
    set_mem(0, 16'h0400, 8'h85);
    op("R6", M_ST_HIGH, R_A, R_A, 1);
    chk("R6", "store address", dst_addr, 16'hFF85);
    chk("R6", "store flag and data", {dst_mem, fetched}, {1'b1, 16'h005A});
    rd_reg(R_PC, v); chk("R6", "pc after store", v, 16'h0401);
    wr_reg(R_PC, 16'h0400);
    op("R6", M_LD_HIGH, R_A, R_A, 2);
    chk("R6", "load page read", rd_log[1], 16'hFF85);
    chk("R6", "load data", fetched, {8'h00, bg(16'hFF85)});
    chk("R6", "load dst_mem", dst_mem, 0);
  endtask

  task automatic t_hl_load();
    logic [15:0] v;
    clr_mem(); wr_reg(R_HL, 16'hC0FF);
    op("R7", M_LD_HLINC, R_A, R_HL, 1);
    chk("R7", "inc read address", rd_log[0], 16'hC0FF);
    chk("R7", "inc data", fetched, {8'h00, bg(16'hC0FF)});
    rd_reg(R_HL, v); chk("R7", "hl after inc", v, 16'hC100);
    op("R7", M_LD_HLDEC, R_A, R_HL, 1);
    chk("R7", "dec read address", rd_log[0], 16'hC100);
    rd_reg(R_HL, v); chk("R7", "hl after dec", v, 16'hC0FF);
    wr_reg(R_HL, 16'h0000);
    op("R7", M_LD_HLDEC, R_A, R_HL, 1);
    rd_reg(R_HL, v); chk("R7", "hl wrap below zero", v, 16'hFFFF);
    op("R7", M_LD_HLINC, R_A, R_HL, 1);
    rd_reg(R_HL, v); chk("R7", "hl wrap above max", v, 16'h0000);
  endtask

  task automatic t_hl_store();
    logic [15:0] v;
    wr_reg(R_HL, 16'hD000); wr_reg(R_A, 16'h005A);
    op("R8", M_ST_HLINC, R_HL, R_A, 0);
    chk("R8", "inc store address", dst_addr, 16'hD000);
    chk("R8", "inc flag and data", {dst_mem, fetched}, {1'b1, 16'h005A});
    rd_reg(R_HL, v); chk("R8", "hl after inc store", v, 16'hD001);
    op("R8", M_ST_HLDEC, R_HL, R_A, 0);
    chk("R8", "dec store address", dst_addr, 16'hD001);
    rd_reg(R_HL, v); chk("R8", "hl after dec store", v, 16'hD000);
  endtask

  task automatic t_abs();
    logic [15:0] v;
    clr_mem(); wr_reg(R_PC, 16'h0500);
    set_mem(0, 16'h0500, 8'h10); set_mem(1, 16'h0501, 8'hC2);
    op("R9", M_LD_ABS, R_A, R_A, 3);
    chk("R9", "data read address", rd_log[2], 16'hC210);
    chk("R9", "load data", fetched, {8'h00, bg(16'hC210)});
    rd_reg(R_PC, v); chk("R9", "pc after load", v, 16'h0502);
    wr_reg(R_PC, 16'h0500); wr_reg(R_SP, 16'hFFFE);
    op("R9", M_ST_ABS, R_A, R_SP, 2);
    chk("R9", "store address", dst_addr, 16'hC210);
    chk("R9", "store flag and data", {dst_mem, fetched}, {1'b1, 16'hFFFE});
  endtask

  task automatic t_sprel();
    logic [15:0] v;
    logic [15:0] sp_v;
    logic [7:0]  ofs, f_in, f_exp;
    clr_mem();
    for (int t = 0; t < 2; t++) begin
      sp_v = (t == 0) ? 16'h00F8 : 16'h1000;
      ofs  = (t == 0) ? 8'h08 : 8'hFE;
      f_in = (t == 0) ? 8'hCF : 8'hF5;
      wr_reg(R_SP, sp_v); wr_reg(R_F, {8'h00, f_in}); wr_reg(R_PC, 16'h0700);
      set_mem(0, 16'h0700, ofs);
      op("R10", M_SP_REL, R_HL, R_SP, 1);
      f_exp = {2'b00, ((sp_v & 16'hF) + (ofs & 8'hF)) > 15,
               ((sp_v & 16'hFF) + ofs) > 255, f_in[3:0]};
      chk("R10", "sum", fetched, (t == 0) ? 16'h0100 : 16'h0FFE);
      rd_reg(R_F, v); chk("R10", "flags", v, {8'h00, f_exp});
      rd_reg(R_PC, v); chk("R10", "pc", v, 16'h0701);
    end
  endtask

  task automatic t_regonly();
    wr_reg(R_BC, 16'hBEEF);
    op("R11", M_REG, R_A, R_BC, 0);
    chk("R11", "register mode value", fetched, 16'hBEEF);
    chk("R11", "register mode dst_mem", dst_mem, 0);
    @(negedge clk);
    chk("R11", "done single pulse", done, 0);
    op("R11", M_NONE, R_A, R_BC, 0);
    chk("R11", "none mode value", fetched, 16'h0000);
  endtask

  task automatic t_bad();
    int seen_done, seen_rd;
    logic [15:0] v, pc0;
    seen_done = 0; seen_rd = 0;
    rd_reg(R_PC, pc0);
    @(negedge clk); start = 1'b1; mode = M_BAD;
    @(negedge clk); start = 1'b0;
    chk("R12", "err set", err, 1);
    chk("R12", "idle after bad", busy, 0);
    for (int i = 0; i < 4; i++) begin
      if (done) seen_done++;
      if (mem_rd) seen_rd++;
      @(negedge clk);
    end
    chk("R12", "no done", seen_done, 0);
    chk("R12", "no reads", seen_rd, 0);
    rd_reg(R_PC, v); chk("R12", "pc untouched", v, pc0);
    clr_mem(); wr_reg(R_PC, 16'h0800); set_mem(0, 16'h0800, 8'h21);
    op("R12", M_IMM8, R_A, R_A, 1);
    chk("R12", "new start accepted", fetched, 16'h0021);
    chk("R12", "err sticky", err, 1);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    clr_mem(); wr_reg(R_PC, 16'h0600); wr_reg(R_B, 16'h0011);
    set_mem(0, 16'h0600, 8'h20); set_mem(1, 16'h0601, 8'hC3);
    @(negedge clk); start = 1'b1; mode = M_LD_ABS;
    @(negedge clk); start = 1'b1; mode = M_IMM8;
    rf_we = 1'b1; rf_sel = R_B; rf_wdata = 16'h0077;
    @(negedge clk); start = 1'b0; rf_we = 1'b0;
    wait_done();
    chk("R13", "latency of first op", lat, 3);
    chk("R13", "data of first op", fetched, {8'h00, bg(16'hC320)});
    @(negedge clk);
    chk("R13", "no second op", {busy, done}, 0);
    rd_reg(R_PC, v); chk("R13", "pc", v, 16'h0602);
    rd_reg(R_B, v); chk("R2", "write ignored while busy", v, 16'h0011);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    clr_mem();
    for (int k = 0; k < 4; k++) begin ov_addr[k] = '0; ov_data[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regport();
    t_imm8();
    t_imm16();
    t_indirect();
    t_high();
    t_hl_load();
    t_hl_store();
    t_abs();
    t_sprel();
    t_regonly();
    t_busy();
    t_bad();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule